// File: doc/BRIEF.md
# Deferred-Carry Multi-Operand Accumulator

This block adds up a long stream of 256-bit unsigned operands. The running sum is kept in a redundant form of five limbs. Four lower limbs carry 51 result bits each and the top limb carries 52. Each limb lives in a 64-bit register. When an operand is accepted, each of its limbs is added into its own register with a plain wide add. No carry crosses a limb boundary, so the extra high bits of each register act as headroom that collects carries. One accumulate step therefore costs a single 64-bit add per limb, whatever the operand values.

When the host wants the total, it pulses a normalize command. The block then runs parallel carry passes. In each pass every lower limb hands the bits above its 51-bit field to the next limb up, and it keeps only its own 51 bits. Carries out of the top limb are dropped, so the result is the sum modulo 2^256. A single pass can leave a new carry behind when a limb's low field was all ones, so passes repeat until all lower headroom is empty. The block then pulses done and holds the canonical 256-bit result on its output.

The host streams operands with a valid/ready handshake. A clear command restarts the sum. An operand counter stalls the input before any limb register could wrap. The host must then normalize or clear before more operands are taken.

Top module: `carry_defer_acc`

## Requirements
- R1: After reset, sum_o is zero, done_o and risk_o are low and op_ready_o is high.
- R2: Operand bits [50:0], [101:51], [152:102] and [203:153] form the lower limbs 0 to 3. Bits [255:204] form the top limb. sum_o uses the same bit positions, so a single operand normalized after a clear comes back unchanged.
- R3: An operand is accepted at a rising clock edge where op_valid_i and op_ready_o are both high. Its limbs are added into the limb registers without inter-limb carry, and no lower limb register wraps.
- R4: norm_i sampled high while the block is accumulating starts normalization. An operand accepted at that same edge is part of the result.
- R5: Normalization repeats parallel carry passes until every lower limb's headroom is zero. This holds even when carries ripple through several limbs whose 51-bit fields are all ones.
- R6: When normalization finishes, done_o is high for exactly one cycle. While it is high, sum_o equals the sum of all accepted operands since the last clear, modulo 2^256.
- R7: op_ready_o is low from the edge where normalization starts until done_o rises.
- R8: The counter is zeroed by clear and set to one by each normalization. Each accepted operand raises it by one. When it reaches 8192, risk_o goes high and op_ready_o goes low, and further valid operands are not taken until a clear or normalize.
- R9: clr_i has priority. It zeroes every limb and the counter in one cycle, holds op_ready_o low while high, and aborts a running normalization without a done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Zero the sum and counter |
| norm_i | input | 1 | Start normalization |
| op_valid_i | input | 1 | Operand present |
| op_data_i | input | 256 | Operand |
| op_ready_o | output | 1 | Operand can be taken this cycle |
| risk_o | output | 1 | Headroom budget used up |
| done_o | output | 1 | One-cycle pulse, sum_o canonical |
| sum_o | output | 256 | Normalized sum modulo 2^256 |

## Verification
The no-wrap property on each lower limb only holds if every operand limb fits its 51-bit field and the counter budget is respected. Both follow from the operand port being exactly 256 bits and from the ready stall at 8192. The stimulus also reaches that stall with all-ones operands, which is the worst case. The done and stall properties assume norm_i is a single-cycle request. The bench drives it that way, except for a deliberate clear issued in the middle of a pass. Random operands are mixed with all-ones lower fields and top-bit-only values, so that multi-pass ripples and the 2^256 wrap both occur.

// File: rtl/carry_defer_acc.sv
module carry_defer_acc #(
  parameter int LIMB_W = 51,
  parameter int TOP_W  = 52,
  parameter int REG_W  = 64,
  parameter int NLIMB  = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr_i,
  input  logic                                 norm_i,
  input  logic                                 op_valid_i,
  input  logic [(NLIMB-1)*LIMB_W+TOP_W-1:0]    op_data_i,
  output logic                                 op_ready_o,
  output logic                                 risk_o,
  output logic                                 done_o,
  output logic [(NLIMB-1)*LIMB_W+TOP_W-1:0]    sum_o
);
  localparam int OP_W   = (NLIMB-1)*LIMB_W + TOP_W;
  localparam int HEAD_W = REG_W - LIMB_W;
  localparam int CNT_W  = HEAD_W + 1;
  localparam logic [CNT_W-1:0] MAX_OPS  = {1'b1, {HEAD_W{1'b0}}};
  localparam logic [CNT_W-1:0] ONE_CNT  = {{HEAD_W{1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] LOW_MASK = {{HEAD_W{1'b0}}, {LIMB_W{1'b1}}};
  localparam logic [REG_W-1:0] TOP_MASK = {{(REG_W-TOP_W){1'b0}}, {TOP_W{1'b1}}};

  logic [REG_W-1:0] limb_q  [NLIMB];
  logic [REG_W-1:0] op_limb [NLIMB];
  logic [REG_W-1:0] cin     [NLIMB];
  logic [NLIMB-2:0] hr_busy;
  logic [CNT_W-1:0] cnt_q;
  logic norm_q, done_q, accept, canon;

  assign risk_o     = (cnt_q == MAX_OPS);
  assign op_ready_o = !norm_q && !clr_i && !risk_o;
  assign accept     = op_valid_i && op_ready_o;
  assign canon      = (hr_busy == '0);
  assign done_o     = done_q;

  for (genvar g = 0; g < NLIMB; g++) begin : g_limb
    if (g == 0) begin : g_cin0
      assign cin[g] = '0;
    end else begin : g_cinn
      assign cin[g] = limb_q[g-1] >> LIMB_W;
    end
    if (g == NLIMB-1) begin : g_top
      assign op_limb[g] = REG_W'(op_data_i[OP_W-1 -: TOP_W]);
      assign sum_o[OP_W-1 -: TOP_W] = limb_q[g][TOP_W-1:0];
    end else begin : g_low
      assign op_limb[g] = REG_W'(op_data_i[g*LIMB_W +: LIMB_W]);
      assign sum_o[g*LIMB_W +: LIMB_W] = limb_q[g][LIMB_W-1:0];
      assign hr_busy[g] = |limb_q[g][REG_W-1:LIMB_W];

      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> limb_q[g] >= $past(limb_q[g])) else $error("lower limb wrapped"); // R3
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLIMB; i++) limb_q[i] <= '0;
      cnt_q  <= '0;
      norm_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        for (int i = 0; i < NLIMB; i++) limb_q[i] <= '0;
        cnt_q  <= '0;
        norm_q <= 1'b0;
      end else if (norm_q) begin
        if (canon) begin
          limb_q[NLIMB-1] <= limb_q[NLIMB-1] & TOP_MASK;
          norm_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= ONE_CNT;
        end else begin
          for (int i = 0; i < NLIMB; i++) begin
            if (i == NLIMB-1) limb_q[i] <= limb_q[i] + cin[i];
            else              limb_q[i] <= (limb_q[i] & LOW_MASK) + cin[i];
          end
        end
      end else begin
        if (accept) begin
          for (int i = 0; i < NLIMB; i++) limb_q[i] <= limb_q[i] + op_limb[i];
          cnt_q <= cnt_q + ONE_CNT;
        end
        if (norm_i) norm_q <= 1'b1;
      end
    end
  end

  AST_DONE_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hr_busy == '0) && (limb_q[NLIMB-1][REG_W-1:TOP_W] == '0)) else $error("done with carries left"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R6
  AST_STALL_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_i && !norm_q && !clr_i) |=> !op_ready_o) else $error("ready during normalize"); // R7
  AST_RISK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (risk_o && !clr_i && !norm_q && !norm_i) |=> risk_o) else $error("risk dropped"); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_o == '0) && !done_o) else $error("clear incomplete"); // R9
endmodule

// File: tb/carry_defer_acc_bench.sv
`timescale 1ns/1ps
module carry_defer_acc_bench;
  logic clk = 1'b0, rst_n = 1'b0, clr_i = 1'b0, norm_i = 1'b0, op_valid_i = 1'b0;
  logic [255:0] op_data_i = '0;
  logic op_ready_o, risk_o, done_o;
  logic [255:0] sum_o;

  int errors = 0, checks = 0, cyc = 0;
  logic [255:0] ref_sum = '0;
  localparam logic [255:0] LOW_ONES = (256'd1 << 204) - 256'd1;
  localparam logic [255:0] ALL_ONES = '1;
  localparam logic [255:0] TOP_BIT  = 256'd1 << 255;

  carry_defer_acc u_carry_defer_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .norm_i(norm_i),
    .op_valid_i(op_valid_i), .op_data_i(op_data_i), .op_ready_o(op_ready_o),
    .risk_o(risk_o), .done_o(done_o), .sum_o(sum_o));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [255:0] v);
    op_valid_i = 1'b1;
    op_data_i  = v;
    while (!op_ready_o) @(negedge clk);
    @(negedge clk);
    op_valid_i = 1'b0;
    ref_sum = ref_sum + v;
  endtask

  task automatic run_norm(input string tag);
    int n;
    norm_i = 1'b1;
    @(negedge clk);
    norm_i = 1'b0;
    chk(op_ready_o == 1'b0, {"R7 ready low while normalizing ", tag}, 256'(op_ready_o), 256'd0);
    n = 0;
    while (!done_o && n < 40) begin @(negedge clk); n++; end
    chk(done_o == 1'b1, {"R5 normalization finished ", tag}, 256'(done_o), 256'd1);
    chk(sum_o == ref_sum, {"R6 sum ", tag}, sum_o, ref_sum);
    @(negedge clk);
    chk(done_o == 1'b0, {"R6 done single cycle ", tag}, 256'(done_o), 256'd0);
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    @(negedge clk);
    chk(op_ready_o == 1'b0, "R9 ready low during clear", 256'(op_ready_o), 256'd0);
    clr_i = 1'b0;
    @(negedge clk);
    chk(sum_o == '0, "R9 sum zero after clear", sum_o, '0);
    ref_sum = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog R6 actual=%0d expected<=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] pat;
    bit seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum_o == '0, "R1 sum after reset", sum_o, '0);
    chk(done_o == 1'b0, "R1 done after reset", 256'(done_o), 256'd0);
    chk(risk_o == 1'b0, "R1 risk after reset", 256'(risk_o), 256'd0);
    chk(op_ready_o == 1'b1, "R1 ready after reset", 256'(op_ready_o), 256'd1);

    // R2: single operand with distinct limb patterns round-trips
    pat = {52'hA_BCDE_F012_3456, 51'h1_2345_6789_ABCD, 51'h5_5555_5555_5555,
           51'h2_AAAA_AAAA_AAAA, 51'h7_0F0F_0F0F_0F0F};
    send(pat);
    run_norm("R2 limb layout");
    chk(sum_o == pat, "R2 operand round trip", sum_o, pat);

    // R5: ripple through all lower limbs
    do_clear();
    send(LOW_ONES);
    send(256'd1);
    run_norm("R5 ripple 2^204");
    chk(sum_o == (256'd1 << 204), "R5 ripple value", sum_o, 256'd1 << 204);
    do_clear();
    send(LOW_ONES); send(LOW_ONES); send(256'd2);
    run_norm("R5 double ripple");

    // R3/R6: wrap modulo 2^256
    do_clear();
    send(TOP_BIT); send(TOP_BIT); send(256'd5);
    run_norm("R6 top wrap");
    chk(sum_o == 256'd5, "R6 wrap value", sum_o, 256'd5);

    // R4: operand in the same cycle as norm_i is included
    do_clear();
    send(ALL_ONES);
    op_valid_i = 1'b1; op_data_i = 256'd7; norm_i = 1'b1;
    @(negedge clk);
    op_valid_i = 1'b0; norm_i = 1'b0;
    ref_sum = ref_sum + 256'd7;
    seen = 1'b0;
    for (int n = 0; n < 40 && !seen; n++) begin
      if (done_o) seen = 1'b1; else @(negedge clk);
    end
    chk(seen && sum_o == ref_sum, "R4 same-cycle operand included", sum_o, ref_sum);
    @(negedge clk);

    // R3/R6: random batches, sum carried across normalizations
    do_clear();
    for (int b = 0; b < 14; b++) begin
      int cnt;
      cnt = 1 + int'($urandom % 40);
      for (int k = 0; k < cnt; k++) begin
        case ($urandom % 4)
          0: send(LOW_ONES);
          1: send(TOP_BIT | rnd256() >> 200);
          default: send(rnd256());
        endcase
      end
      run_norm("R3 random batch");
    end

    // R8: budget stall with worst-case operands
    do_clear();
    for (int k = 0; k < 8192; k++) send(ALL_ONES);
    chk(risk_o == 1'b1, "R8 risk at 8192", 256'(risk_o), 256'd1);
    chk(op_ready_o == 1'b0, "R8 ready low at 8192", 256'(op_ready_o), 256'd0);
    op_valid_i = 1'b1; op_data_i = 256'd99;
    repeat (3) @(negedge clk);
    op_valid_i = 1'b0;
    run_norm("R8 extra operand refused");
    chk(risk_o == 1'b0, "R8 risk cleared by normalize", 256'(risk_o), 256'd0);
    for (int k = 0; k < 8191; k++) send(ALL_ONES);
    chk(risk_o == 1'b1, "R8 risk after 8191 post-normalize", 256'(risk_o), 256'd1);
    run_norm("R8 second budget");

    // R9: clear aborts a running normalization
    do_clear();
    send(LOW_ONES); send(256'd1);
    norm_i = 1'b1;
    @(negedge clk);
    norm_i = 1'b0;
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    ref_sum = '0;
    seen = 1'b0;
    for (int n = 0; n < 12; n++) begin
      if (done_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R9 no done after aborted normalize", 256'(seen), 256'd0);
    chk(sum_o == '0, "R9 sum zero after abort", sum_o, '0);
    chk(op_ready_o == 1'b1, "R9 ready after abort", 256'(op_ready_o), 256'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule